// File: doc/BRIEF.md
# Transmit Guard for a Dual Bus Transceiver

This block sits between each channel's transmit-data input and that channel's bus driver. It decides, on every clock cycle, two things for each channel. The first is whether the transmitter is enabled at all. The second is whether it should drive a dominant level.

A channel drives dominant only when all of the following hold:
- the channel is in normal mode;
- the supply is above its undervoltage level;
- the shared over-temperature flag is low;
- no lockout is active.

Two lockouts can stop dominant drive, and both release only after the transmit-data line goes back high. The dominant-time limit stops a stuck-low transmit line from holding the bus. The thermal lockout stops transmission from restarting in the middle of a frame after the part has cooled down.

The channels are independent copies with their own mode, timer and lockout state. The over-temperature flag and the undervoltage flag are shared by all channels. The transmit input is active low: 0 requests dominant. The analog driver, slope shaping and temperature sensing are outside this block. The block only produces the digital enable and dominant-request levels.

Top module: `txguard_dual`

## Requirements
- R1: With the transmitter enabled and no lockout active, `drive_dom[i]` equals the inverse of `txd_n[i]` in the same cycle. `txd_n[i]=1` never gives dominant.
- R2: A timer counts clock edges at which channel i is enabled with `txd_n[i]=0`. Once it reaches `TMO_CYC`, `drive_dom[i]` returns to 0. A continuous dominant therefore lasts at most `TMO_CYC` cycles.
- R3: The timer clears only at an edge where `txd_n[i]=1`. After that, a new low gets a full `TMO_CYC` window. The timer saturates, so a low held for any length never re-enables dominant.
- R4: While `hot_flag=1`, `drive_dom` is 0 on every channel in the same cycle. `tx_en` is not affected by `hot_flag`.
- R5: A thermal lockout is armed at every edge where `hot_flag=1`. It is cleared only at an edge where `hot_flag=0` and `txd_n[i]=1`. While it is armed, `drive_dom[i]` is 0.
- R6: In standby (mode state 1), `tx_en[i]=0` and `drive_dom[i]=0`, whatever the value of `txd_n[i]`.
- R7: `stby_req[i]=1` requests standby and 0 requests normal. The mode changes after the request has differed from the current mode for `MODE_DLY` consecutive edges. A shorter excursion has no effect.
- R8: While `uv_flag=1`, `tx_en` and `drive_dom` are 0 on all channels in the same cycle. The dominant timer does not advance while the transmitter is disabled.
- R9: Reset puts every channel in standby with `tx_en=0`, `drive_dom=0`, the timer at 0 and the thermal lockout armed. The first dominant after reset therefore needs `txd_n` to have been high at some edge.
- R10: Each channel's mode, timer and lockout depend only on its own inputs and the shared flags. Activity on one channel does not change another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txd_n | input | NCH | Per-channel transmit data, 0 requests dominant |
| stby_req | input | NCH | Per-channel mode request, 1 standby, 0 normal |
| hot_flag | input | 1 | Shared over-temperature flag |
| uv_flag | input | 1 | Shared supply undervoltage flag |
| tx_en | output | NCH | Per-channel transmitter enable |
| drive_dom | output | NCH | Per-channel dominant drive request |

## Verification
Faults in the timer or in a lockout show up as a dominant that lasts one cycle too long or too short. They also show up as a dominant that reappears while `txd_n` is still low after a timeout or a cool-down. Either error is visible on `drive_dom` in the very cycle it occurs. A faulty mode counter moves the `tx_en` edge away from exactly `MODE_DLY` cycles after a held request, or lets a short glitch through. A channel crosstalk fault only appears when the other channel's inputs are held differently, so the sweep runs every input combination across both channels and several hold lengths.

// File: rtl/txg_pkg.sv
package txg_pkg;
  typedef enum logic {
    MODE_NORMAL  = 1'b0,
    MODE_STANDBY = 1'b1
  } txg_mode_e;

  typedef struct packed {
    logic tx_en;
    logic drive_dom;
  } txg_out_t;
endpackage

// File: rtl/txg_mode_ctl.sv
module txg_mode_ctl
  import txg_pkg::*;
#(
  parameter int MODE_DLY = 1000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stby_req,
  output txg_mode_e mode
);
  localparam int MW = (MODE_DLY > 1) ? $clog2(MODE_DLY) : 1;

  txg_mode_e mode_q;
  logic      req_differs;

  assign req_differs = (stby_req != logic'(mode_q));
  assign mode        = mode_q;

  generate
    if (MODE_DLY <= 1) begin : g_direct
      // Single-edge switch: no qualification counter needed.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_STANDBY;
        else if (req_differs) mode_q <= txg_mode_e'(stby_req);
      end
    end else begin : g_counted
      logic [MW-1:0] dly_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mode_q <= MODE_STANDBY;
          dly_q  <= '0;
        end else if (!req_differs) begin
          dly_q <= '0;
        end else if (dly_q == MW'(MODE_DLY - 1)) begin
          mode_q <= txg_mode_e'(stby_req);
          dly_q  <= '0;
        end else begin
          dly_q <= dly_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/txg_dom_timer.sv
module txg_dom_timer #(
  parameter int TMO_CYC = 81250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_n,
  input  logic tx_en,
  output logic expired
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0] TMAX = TW'(TMO_CYC);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (txd_n)                    cnt_q <= '0;
    else if (tx_en && (cnt_q != TMAX)) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == TMAX);
endmodule

// File: rtl/txg_therm_latch.sv
module txg_therm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hot,
  input  logic txd_n,
  output logic block
);
  logic lock_q;

  // Armed out of reset: a stuck-low input cannot drive dominant right after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b1;
    else        lock_q <= hot | (lock_q & ~txd_n);
  end

  assign block = hot | lock_q;
endmodule

// File: rtl/txg_channel.sv
module txg_channel
  import txg_pkg::*;
#(
  parameter int TMO_CYC  = 81250,
  parameter int MODE_DLY = 1000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     txd_n,
  input  logic     stby_req,
  input  logic     hot,
  input  logic     uv,
  output txg_out_t outs
);
  txg_mode_e mode;
  logic      enable;
  logic      expired;
  logic      thermal_block;

  txg_mode_ctl #(.MODE_DLY(MODE_DLY)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .stby_req(stby_req),
    .mode    (mode)
  );

  assign enable = (mode == MODE_NORMAL) && !uv;

  txg_dom_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .txd_n  (txd_n),
    .tx_en  (enable),
    .expired(expired)
  );

  txg_therm_latch u_therm (
    .clk  (clk),
    .rst_n(rst_n),
    .hot  (hot),
    .txd_n(txd_n),
    .block(thermal_block)
  );

  assign outs.tx_en     = enable;
  assign outs.drive_dom = enable && !txd_n && !expired && !thermal_block;
endmodule

// File: rtl/txguard_dual.sv
module txguard_dual
  import txg_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int TMO_CYC  = 81250,
  parameter int MODE_DLY = 1000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] txd_n,
  input  logic [NCH-1:0] stby_req,
  input  logic           hot_flag,
  input  logic           uv_flag,
  output logic [NCH-1:0] tx_en,
  output logic [NCH-1:0] drive_dom
);
  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      txg_out_t ch_out;
      txg_channel #(.TMO_CYC(TMO_CYC), .MODE_DLY(MODE_DLY)) u_ch (
        .clk     (clk),
        .rst_n   (rst_n),
        .txd_n   (txd_n[i]),
        .stby_req(stby_req[i]),
        .hot     (hot_flag),
        .uv      (uv_flag),
        .outs    (ch_out)
      );
      assign tx_en[i]     = ch_out.tx_en;
      assign drive_dom[i] = ch_out.drive_dom;
    end
  endgenerate
endmodule

// File: rtl/txguard_dual_chk.sv
module txguard_dual_chk #(
  parameter int NCH      = 2,
  parameter int TMO_CYC  = 81250,
  parameter int MODE_DLY = 1000
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] txd_n,
  input logic [NCH-1:0] stby_req,
  input logic           hot_flag,
  input logic           uv_flag,
  input logic [NCH-1:0] tx_en,
  input logic [NCH-1:0] drive_dom
);
  AST_RESET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (tx_en == '0)); // R9

  AST_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |-> (tx_en == '0) && (drive_dom == '0)); // R8

  AST_HOT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    hot_flag |-> (drive_dom == '0)); // R4

  AST_HOT_HOLDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hot_flag) |-> (drive_dom == '0)); // R5

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_chk
      int dom_run;
      int stby_run;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dom_run  <= 0;
          stby_run <= 0;
        end else begin
          dom_run  <= drive_dom[i] ? dom_run + 1 : 0;
          stby_run <= !stby_req[i] ? 0 : (stby_run < MODE_DLY ? stby_run + 1 : stby_run);
        end
      end

      AST_TXD_HIGH_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        txd_n[i] |-> !drive_dom[i]); // R1

      AST_DOM_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        drive_dom[i] |-> (dom_run < TMO_CYC)); // R2

      AST_DOM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        drive_dom[i] |-> tx_en[i]); // R6

      AST_STBY_TAKES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_run >= MODE_DLY) |-> !tx_en[i]); // R7
    end
  endgenerate
endmodule

bind txguard_dual txguard_dual_chk #(.NCH(NCH), .TMO_CYC(TMO_CYC), .MODE_DLY(MODE_DLY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .txd_n    (txd_n),
  .stby_req (stby_req),
  .hot_flag (hot_flag),
  .uv_flag  (uv_flag),
  .tx_en    (tx_en),
  .drive_dom(drive_dom)
);

// File: tb/tb_txguard_dual.sv
`timescale 1ns/1ps
module tb_txguard_dual;
  localparam int NCH = 2;
  localparam int TMO = 12;
  localparam int MD  = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] txd_n;
  logic [NCH-1:0] stby_req;
  logic           hot_flag;
  logic           uv_flag;
  logic [NCH-1:0] tx_en;
  logic [NCH-1:0] drive_dom;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Reference state, one entry per channel
  bit m_stby  [NCH];
  int m_mcnt  [NCH];
  int m_tcnt  [NCH];
  bit m_tlock [NCH];

  always #4 clk = ~clk;

  txguard_dual #(.NCH(NCH), .TMO_CYC(TMO), .MODE_DLY(MD)) dut (
    .clk(clk), .rst_n(rst_n), .txd_n(txd_n), .stby_req(stby_req),
    .hot_flag(hot_flag), .uv_flag(uv_flag), .tx_en(tx_en), .drive_dom(drive_dom)
  );

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_stby[c] = 1'b1; m_mcnt[c] = 0; m_tcnt[c] = 0; m_tlock[c] = 1'b1;
    end
  endtask

  // Called at a falling edge with inputs already set.
  task automatic step(input string tag);
    bit e_en, e_dom, en_now [NCH];
    #3;
    for (int c = 0; c < NCH; c++) begin
      e_en  = !m_stby[c] && !uv_flag;
      e_dom = e_en && !txd_n[c] && (m_tcnt[c] < TMO) && !hot_flag && !m_tlock[c];
      en_now[c] = e_en;
      n_vec++;
      if (tx_en[c] !== e_en || drive_dom[c] !== e_dom) begin
        n_fail++;
        $display("FAIL %s ch%0d t=%0t: tx_en=%b exp %b, drive_dom=%b exp %b",
                 tag, c, $time, tx_en[c], e_en, drive_dom[c], e_dom);
      end
    end
    @(posedge clk);
    if (!rst_n) model_reset();
    else begin
      for (int c = 0; c < NCH; c++) begin
        if (stby_req[c] != m_stby[c]) begin
          if (m_mcnt[c] == MD - 1) begin m_stby[c] = stby_req[c]; m_mcnt[c] = 0; end
          else m_mcnt[c]++;
        end else m_mcnt[c] = 0;
        if (txd_n[c]) m_tcnt[c] = 0;
        else if (en_now[c] && m_tcnt[c] < TMO) m_tcnt[c]++;
        m_tlock[c] = hot_flag | (m_tlock[c] & !txd_n[c]);
      end
    end
    @(negedge clk);
  endtask

  task automatic hold(input int n, input string tag);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  initial begin
    model_reset();
    rst_n = 1'b0; txd_n = 2'b10; stby_req = 2'b11; hot_flag = 1'b0; uv_flag = 1'b0;
    @(negedge clk);
    hold(3, "R9");
    // Leave reset, request normal; ch0 transmit still low
    rst_n = 1'b1; stby_req = 2'b00;
    hold(MD + 2, "R7");
    hold(3, "R9");
    txd_n = 2'b11; hold(1, "R9");
    // R1: plain data patterns
    for (int k = 0; k < 8; k++) begin txd_n = k[1:0]; hold(1 + k % 3, "R1"); end
    txd_n = 2'b11; hold(1, "R1");
    // R7: short glitch on ch1, then a full request
    stby_req = 2'b10; hold(MD - 1, "R7");
    stby_req = 2'b00; hold(2, "R7");
    stby_req = 2'b10; hold(MD + 2, "R7");
    stby_req = 2'b00; hold(MD - 1, "R7");
    stby_req = 2'b10; hold(1, "R7");
    stby_req = 2'b00; hold(MD + 2, "R7");
    // R2 and R3: timeout, release, saturation
    txd_n = 2'b10; hold(TMO + 4, "R2");
    txd_n = 2'b11; hold(1, "R3");
    txd_n = 2'b00; hold(TMO + 2, "R2");
    txd_n = 2'b01; hold(3 * TMO, "R3");
    txd_n = 2'b11; hold(2, "R3");
    // R4 and R5: thermal block and holdover
    txd_n = 2'b00; hold(2, "R4");
    hot_flag = 1'b1; hold(3, "R4");
    hot_flag = 1'b0; hold(3, "R5");
    txd_n = 2'b11; hold(1, "R5");
    txd_n = 2'b00; hold(2, "R5");
    txd_n = 2'b11; hot_flag = 1'b1; hold(2, "R4");
    hot_flag = 1'b0; txd_n = 2'b00; hold(3, "R5");
    txd_n = 2'b11; hold(1, "R5");
    // R6: standby ignores data
    stby_req = 2'b11; hold(MD + 2, "R6");
    for (int k = 0; k < 6; k++) begin txd_n = k[1:0]; hold(1, "R6"); end
    txd_n = 2'b11; stby_req = 2'b00; hold(MD + 2, "R6");
    // R8: undervoltage, timer frozen while disabled
    txd_n = 2'b00; hold(TMO - 3, "R8");
    uv_flag = 1'b1; hold(5, "R8");
    uv_flag = 1'b0; hold(6, "R8");
    txd_n = 2'b11; hold(1, "R8");
    // R10: every input combination at several hold lengths
    for (int combo = 0; combo < 64; combo++) begin
      for (int h = 0; h < 3; h++) begin
        txd_n    = combo[1:0];
        stby_req = combo[3:2];
        hot_flag = combo[4];
        uv_flag  = combo[5];
        hold(h == 0 ? 1 : (h == 1 ? MD - 1 : TMO + 2), "R10");
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hung exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule